// File: doc/BRIEF.md
# Nibble Instruction Decoder with Operand Prefixing

This block takes a stream of byte-wide instructions, one byte per valid cycle, and turns each one that is not a prefix into a decoded operation. The high nibble of every byte selects one of sixteen functions. The low nibble carries four bits of immediate data. An internal 32-bit operand register lets prefix bytes build operands wider than four bits, one nibble at a time. One prefix code extends the value as it stands. The other extends its bitwise complement, which is how negative values are formed.

A decoded operation appears one cycle after its byte. It carries the function code, the full operand, a flag that marks the operate function (whose operand is an extended, operand-free opcode) and, for the workspace load and store functions, a word-scaled address relative to the workspace pointer. Fetch, execution and memory access live in other blocks.

Top module: `nib_decode`

## Requirements
- R1: After reset `op_vld_o` is low and the operand register holds zero, so the first plain byte issues its own nibble, zero-extended, as the operand.
- R2: A valid byte whose bits 7:4 are not a prefix code causes `op_vld_o` to be high for exactly the next cycle. In that cycle `func_o` equals bits 7:4 of the byte.
- R3: A positive prefix byte (function code parameter `PFX_POS`, default 0x7) sets the operand register to (register OR nibble) shifted left by 4.
- R4: A negative prefix byte (function code parameter `PFX_NEG`, default 0xF) sets the operand register to NOT(register OR nibble) shifted left by 4.
- R5: A prefix byte issues no operation: `op_vld_o` is low in the following cycle.
- R6: An issuing byte outputs (register OR nibble) on `operand_o` and clears the register to zero, so a byte arriving in the very next cycle starts from zero.
- R7: `ext_op_o` is high with an issued operation only when the function code is 0xE (operate).
- R8: For function codes 0x0 (load local) and 0x1 (store local), `mem_op_o` is high and `eff_addr_o` equals `wsp_i` plus the operand times 4, modulo 2^32. For all other codes `mem_op_o` is low.
- R9: A cycle with `byte_vld_i` low leaves the operand register unchanged and issues nothing.
- R10: Bits shifted out above bit 31 during prefixing are discarded. Nine positive prefixes of nibble 1 followed by a load-constant (0x2) with nibble 1 issue 0x11111111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Instruction byte present this cycle |
| byte_i | input | 8 | Instruction byte: function in 7:4, data nibble in 3:0 |
| wsp_i | input | 32 | Workspace pointer used for local address forming |
| op_vld_o | output | 1 | A decoded operation is present |
| func_o | output | 4 | Function code of the operation |
| operand_o | output | 32 | Full accumulated operand |
| ext_op_o | output | 1 | Operand is an extended opcode (operate function) |
| mem_op_o | output | 1 | Operation is a workspace load or store |
| eff_addr_o | output | 32 | Workspace pointer plus operand times 4 |

## Verification
Issuing an operation and accepting a new prefix can fall in successive cycles. The register clear from the issue and the shift from the prefix then land on neighbouring edges. The bench provokes this by driving an issuing byte, then a prefix, then another issuing byte, with no idle cycle between them. The second operand must contain only the nibbles that followed the first issue. It is compared against a value built by hand from R3 and R6, and any residue carried over from the earlier operand counts as a miscompare.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef logic [NIB_W-1:0] func_t;

  localparam func_t FN_LDL = 4'h0;
  localparam func_t FN_STL = 4'h1;
  localparam func_t FN_LDC = 4'h2;
  localparam func_t FN_OPR = 4'hE;

  function automatic logic is_local(func_t f);
    return (f == FN_LDL) || (f == FN_STL);
  endfunction
endpackage

// File: rtl/nib_operand_acc.sv
module nib_operand_acc
  import nib_pkg::*;
#(
  parameter int    DATA_W  = 32,
  parameter func_t PFX_POS = 4'h7,
  parameter func_t PFX_NEG = 4'hF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  func_t             func_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic              pfx_o,
  output logic [DATA_W-1:0] issue_val_o
);
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] merged;
  logic              is_pos, is_neg;

  assign merged      = acc_q | {{(DATA_W-NIB_W){1'b0}}, nib_i};
  assign is_pos      = func_i == PFX_POS;
  assign is_neg      = func_i == PFX_NEG;
  assign pfx_o       = is_pos || is_neg;
  assign issue_val_o = merged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (vld_i) begin
      if (is_pos)      acc_q <= merged << NIB_W;
      else if (is_neg) acc_q <= (~merged) << NIB_W;
      else             acc_q <= '0;
    end
  end

  assert_clear_after_issue_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !pfx_o) |=> (acc_q == '0));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(acc_q));
  assert_pfx_low_nib_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && pfx_o) |=> (acc_q[NIB_W-1:0] == '0));
endmodule

// File: rtl/nib_addr_gen.sv
module nib_addr_gen #(
  parameter int DATA_W   = 32,
  parameter int SCALE_LG = 2
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] offs_i,
  output logic [DATA_W-1:0] addr_o
);
  generate
    if (SCALE_LG == 0) begin : g_byte
      assign addr_o = base_i + offs_i;
    end else begin : g_word
      assign addr_o = base_i + (offs_i << SCALE_LG);
    end
  endgenerate
endmodule

// File: rtl/nib_decode.sv
module nib_decode
  import nib_pkg::*;
#(
  parameter int    DATA_W   = 32,
  parameter int    SCALE_LG = 2,
  parameter func_t PFX_POS  = 4'h7,
  parameter func_t PFX_NEG  = 4'hF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [DATA_W-1:0] wsp_i,
  output logic              op_vld_o,
  output logic [3:0]        func_o,
  output logic [DATA_W-1:0] operand_o,
  output logic              ext_op_o,
  output logic              mem_op_o,
  output logic [DATA_W-1:0] eff_addr_o
);
  func_t             func_in;
  logic [NIB_W-1:0]  nib_in;
  logic              is_pfx, issue;
  logic [DATA_W-1:0] issue_val, addr_d;

  assign func_in = byte_i[BYTE_W-1:NIB_W];
  assign nib_in  = byte_i[NIB_W-1:0];
  assign issue   = byte_vld_i && !is_pfx;

  nib_operand_acc #(
    .DATA_W (DATA_W),
    .PFX_POS(PFX_POS),
    .PFX_NEG(PFX_NEG)
  ) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (byte_vld_i),
    .func_i     (func_in),
    .nib_i      (nib_in),
    .pfx_o      (is_pfx),
    .issue_val_o(issue_val)
  );

  nib_addr_gen #(
    .DATA_W  (DATA_W),
    .SCALE_LG(SCALE_LG)
  ) u_addr (
    .base_i(wsp_i),
    .offs_i(issue_val),
    .addr_o(addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_vld_o   <= 1'b0;
      func_o     <= '0;
      operand_o  <= '0;
      ext_op_o   <= 1'b0;
      mem_op_o   <= 1'b0;
      eff_addr_o <= '0;
    end else begin
      op_vld_o <= issue;
      if (issue) begin
        func_o     <= func_in;
        operand_o  <= issue_val;
        ext_op_o   <= func_in == FN_OPR;
        mem_op_o   <= is_local(func_in);
        eff_addr_o <= addr_d;
      end
    end
  end

  assert_prefix_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && (func_in == PFX_POS || func_in == PFX_NEG)) |=> !op_vld_o);
  assert_issue_from_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_vld_o |-> $past(byte_vld_i));
  assert_func_follows_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && func_in != PFX_POS && func_in != PFX_NEG) |=> (func_o == $past(func_in)));
  assert_ext_only_operate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_vld_o && ext_op_o) |-> (func_o == FN_OPR));
  assert_local_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_vld_o && mem_op_o) |-> (eff_addr_o == $past(wsp_i) + (operand_o << SCALE_LG)));
  assert_idle_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> !op_vld_o);
endmodule

// File: tb/sim_nib_decode.sv
`timescale 1ns/1ps
module sim_nib_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [7:0]  byt = '0;
  logic [31:0] wsp = 32'h0000_1000;
  logic        op_vld, ext_op, mem_op;
  logic [3:0]  func;
  logic [31:0] operand, eff_addr;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  nib_decode u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(vld), .byte_i(byt), .wsp_i(wsp),
    .op_vld_o(op_vld), .func_o(func), .operand_o(operand), .ext_op_o(ext_op),
    .mem_op_o(mem_op), .eff_addr_o(eff_addr)
  );

  task automatic drive(input logic v, input logic [7:0] b);
    @(negedge clk);
    vld = v;
    byt = b;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_op(input string tag, input logic [3:0] f, input logic [31:0] opd,
                        input logic e, input logic m, input logic [31:0] a);
    chk({tag, " vld"}, {31'b0, op_vld}, 32'd1);
    chk({tag, " func"}, {28'b0, func}, {28'b0, f});
    chk({tag, " operand"}, operand, opd);
    chk({tag, " ext"}, {31'b0, ext_op}, {31'b0, e});
    chk({tag, " mem"}, {31'b0, mem_op}, {31'b0, m});
    if (m) chk({tag, " addr"}, eff_addr, a);
  endtask

  task automatic t_reset();
    chk("R1 vld after reset", {31'b0, op_vld}, 32'd0);
    drive(1, 8'h25);
    drive(0, 8'h00);
    chk_op("R1 first ldc", 4'h2, 32'h5, 0, 0, 0);
    drive(0, 8'h00);
    chk("R2 single pulse", {31'b0, op_vld}, 32'd0);
  endtask

  task automatic t_pos_prefix();
    drive(1, 8'h71); drive(1, 8'h72); drive(1, 8'h73); drive(1, 8'h24);
    drive(0, 8'h00);
    chk_op("R3 pos chain", 4'h2, 32'h0000_1234, 0, 0, 0);
  endtask

  task automatic t_neg_prefix();
    drive(1, 8'hF0); drive(1, 8'h2F); drive(0, 8'h00);
    chk_op("R4 neg minus one", 4'h2, 32'hFFFF_FFFF, 0, 0, 0);
    drive(1, 8'hF1); drive(1, 8'h25); drive(0, 8'h00);
    chk_op("R4 neg nib1", 4'h2, 32'hFFFF_FFE5, 0, 0, 0);
  endtask

  task automatic t_prefix_silent();
    drive(1, 8'h73); drive(0, 8'h00);
    chk("R5 prefix silent", {31'b0, op_vld}, 32'd0);
    drive(0, 8'h00); drive(0, 8'h00);
    chk("R9 idle silent", {31'b0, op_vld}, 32'd0);
    drive(1, 8'h20); drive(0, 8'h00);
    chk_op("R9 hold across idle", 4'h2, 32'h30, 0, 0, 0);
  endtask

  task automatic t_back_to_back();
    drive(1, 8'h71); drive(1, 8'h22); drive(1, 8'h23);
    chk_op("R6 first", 4'h2, 32'h12, 0, 0, 0);
    drive(1, 8'h75);
    chk_op("R6 cleared", 4'h2, 32'h3, 0, 0, 0);
    drive(1, 8'h21); drive(1, 8'h76);
    chk_op("R6 issue then pfx a", 4'h2, 32'h51, 0, 0, 0);
    drive(1, 8'h27); drive(0, 8'h00);
    chk_op("R6 issue then pfx b", 4'h2, 32'h67, 0, 0, 0);
  endtask

  task automatic t_operate();
    drive(1, 8'h71); drive(1, 8'hE3); drive(1, 8'h84);
    chk_op("R7 operate", 4'hE, 32'h13, 1, 0, 0);
    drive(0, 8'h00);
    chk_op("R7 jump not ext", 4'h8, 32'h4, 0, 0, 0);
  endtask

  task automatic t_local();
    drive(1, 8'h13); drive(0, 8'h00);
    chk_op("R8 stl", 4'h1, 32'h3, 0, 1, 32'h0000_100C);
    drive(1, 8'h71); drive(1, 8'h00); drive(0, 8'h00);
    chk_op("R8 ldl prefixed", 4'h0, 32'h10, 0, 1, 32'h0000_1040);
    drive(1, 8'hF0); drive(1, 8'h0F); drive(0, 8'h00);
    chk_op("R8 ldl negative", 4'h0, 32'hFFFF_FFFF, 0, 1, 32'h0000_0FFC);
    @(negedge clk); wsp = 32'hFFFF_FFF0;
    drive(1, 8'h08); drive(0, 8'h00);
    chk_op("R8 wrap", 4'h0, 32'h8, 0, 1, 32'h0000_0010);
    drive(1, 8'h92); drive(0, 8'h00);
    chk_op("R8 cj not mem", 4'h9, 32'h2, 0, 0, 0);
    @(negedge clk); wsp = 32'h0000_1000;
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 9; i++) drive(1, 8'h71);
    drive(1, 8'h21); drive(0, 8'h00);
    chk_op("R10 overflow", 4'h2, 32'h1111_1111, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pos_prefix();
    t_neg_prefix();
    t_prefix_silent();
    t_back_to_back();
    t_operate();
    t_local();
    t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule